// File: doc/BRIEF.md
# Iterative Floating-Point Divider (24-bit word)

This block divides one 24-bit floating-point word by another. A word holds an 8-bit exponent biased by 127 in bits 23:16, a sign in bit 15 and a 15-bit fraction in bits 14:0 behind an implied leading one. The all-zero word is the only zero, and every word with exponent 0 reads as zero. A one-cycle `start` pulse captures both operands and the round and saturate enables. The block then works through a fixed sequence of cycles and finishes with a one-cycle `done` pulse. The quotient and the error indication are held from that pulse until the next one.

The dividend significand is compared with the divisor significand before the division begins. When it is not smaller, it is halved first, so every non-zero quotient already has its leading one in place and no shift is needed afterwards. Sixteen restoring steps each give one quotient bit, one per clock. An optional trial step then decides rounding. Overflow, underflow and division by zero each set a sticky flag that only `clrFlags` clears. With saturation enabled, overflow and underflow return fixed limit codes.

Top module: `fpdiv_top`

## Requirements
- R1: For non-zero operands in range, the quotient sign is the XOR of the operand signs, and the quotient fraction holds the 16-bit truncated ratio of the significands with its leading one dropped.
- R2: When the dividend significand is greater than or equal to the divisor significand, the result exponent is dividend exponent − divisor exponent + 127. Otherwise it is that value minus one (+126).
- R3: With rounding enabled, one is added to the quotient only when the truncated quotient LSB is 1 and the next quotient bit is 1. An even truncated quotient is never rounded, and with rounding disabled the result is always truncated.
- R4: A divisor with exponent 0 raises `err` and sets `dzFlag`, and the quotient is 0x000000 whatever the enables are. This case wins over a zero dividend.
- R5: A dividend with exponent 0 and a non-zero divisor gives 0x000000 with `err` low and no flag change.
- R6: If the computed exponent is above 255, `err` and `ovfFlag` are set. The result is {0xFF, sign, 0x7FFF} with saturation on and 0x000000 with it off. An exponent of exactly 255 is a normal result.
- R7: If the computed exponent is 0 or less, `err` and `unfFlag` are set. The result is {0x01, sign, 0x0000} with saturation on and 0x000000 with it off. An exponent of exactly 1 is a normal result.
- R8: All three flags are 0 after reset. Each stays set across later divisions until a `clrFlags` cycle clears it.
- R9: `done` is a single-cycle pulse, given once for each accepted start. A `start` that arrives while a division is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture operands and begin (ignored while busy) |
| dividend | input | 24 | Dividend word |
| divisor | input | 24 | Divisor word |
| rndEn | input | 1 | Enable rounding |
| satEn | input | 1 | Enable saturation on overflow/underflow |
| clrFlags | input | 1 | Clear the sticky flags |
| quotient | output | 24 | Result word, valid from done |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error for the last result |
| ovfFlag | output | 1 | Sticky overflow |
| unfFlag | output | 1 | Sticky underflow |
| dzFlag | output | 1 | Sticky divide by zero |

## Verification
The rounding decision is the hardest behaviour to reach from the ports. It needs a truncated quotient that is odd and a remainder of at least half the divisor. A random significand pair meets both conditions only about a quarter of the time, and the even-LSB case that suppresses rounding is just as easy to miss. The stimulus therefore includes hand-chosen divisors of 1.625 and 1.25 with dividend 1.0, which give an odd quotient followed by a 1 and an even quotient followed by a 1. Random pairs are added on top, and the bench scores them with an independent model built on integer ratios. The exponent limits are probed exactly at 255/256 and at 1/0.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;
  typedef struct packed {
    logic load;
    logic prep;
    logic step;
    logic rnd;
    logic fin;
  } divStrobe_t;

  typedef struct packed {
    logic bZero;
    logic aZero;
    logic expOvf;
    logic expUnf;
  } divStat_t;

  typedef enum logic [2:0] {
    K_NORM = 3'd0,
    K_ZERO = 3'd1,
    K_DZ   = 3'd2,
    K_OVF  = 3'd3,
    K_UNF  = 3'd4
  } resKind_t;
endpackage

// File: rtl/fpdiv_dp.sv
module fpdiv_dp
  import fpdiv_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16,
  parameter int BIAS  = 127
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  divStrobe_t             stb,
  input  logic [EXP_W+MAN_W-1:0] aIn,
  input  logic [EXP_W+MAN_W-1:0] bIn,
  input  logic                   rndIn,
  input  logic                   satIn,
  input  logic                   clrFlags,
  output divStat_t               stat,
  output logic [EXP_W+MAN_W-1:0] quotient,
  output logic                   done,
  output logic                   err,
  output logic                   ovfFlag,
  output logic                   unfFlag,
  output logic                   dzFlag
);
  localparam int W    = EXP_W + MAN_W;
  localparam int EW   = EXP_W + 2;
  localparam int EMAX = (1 << EXP_W) - 1;
  localparam int FR_W = MAN_W - 1;

  logic [W-1:0]           aR, bR;
  logic                   rndR, satR, signR, inBit;
  logic [MAN_W-1:0]       remR, quoR;
  logic signed [EW-1:0]   expR;
  resKind_t               kindR;

  logic [EXP_W-1:0]       aExp, bExp;
  logic [MAN_W-1:0]       maC, mbC;
  logic [MAN_W:0]         mbX, trialC, diffC, nextC, sumC;
  logic                   alignC, incC, nbC;
  logic signed [EW-1:0]   expC;

  assign aExp   = aR[W-1 -: EXP_W];
  assign bExp   = bR[W-1 -: EXP_W];
  assign maC    = {1'b1, aR[FR_W-1:0]};
  assign mbC    = {1'b1, bR[FR_W-1:0]};
  assign mbX    = {1'b0, mbC};
  assign alignC = (maC >= mbC);
  assign expC   = $signed({2'b00, aExp}) - $signed({2'b00, bExp})
                + $signed(EW'(BIAS - 1)) + $signed({{(EW-1){1'b0}}, alignC});

  assign stat.bZero  = (bExp == '0);
  assign stat.aZero  = (aExp == '0);
  assign stat.expOvf = (expC > $signed(EW'(EMAX)));
  assign stat.expUnf = (expC <= $signed(EW'(0)));

  assign trialC = {remR, inBit};
  assign diffC  = trialC - mbX;
  assign nextC  = {remR, 1'b0};
  assign nbC    = (nextC >= mbX);
  assign incC   = rndR & quoR[0] & nbC;
  assign sumC   = {1'b0, quoR} + {{MAN_W{1'b0}}, incC};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aR <= '0; bR <= '0; rndR <= 1'b0; satR <= 1'b0;
      signR <= 1'b0; inBit <= 1'b0; remR <= '0; quoR <= '0;
      expR <= '0; kindR <= K_ZERO;
    end else begin
      if (stb.load) begin
        aR <= aIn; bR <= bIn; rndR <= rndIn; satR <= satIn;
      end
      if (stb.prep) begin
        signR <= aR[FR_W] ^ bR[FR_W];
        expR  <= expC;
        quoR  <= '0;
        if (alignC) begin
          remR  <= {1'b0, maC[MAN_W-1:1]};
          inBit <= maC[0];
        end else begin
          remR  <= maC;
          inBit <= 1'b0;
        end
        if (stat.bZero)       kindR <= K_DZ;
        else if (stat.aZero)  kindR <= K_ZERO;
        else if (stat.expOvf) kindR <= K_OVF;
        else if (stat.expUnf) kindR <= K_UNF;
        else                  kindR <= K_NORM;
      end
      if (stb.step) begin
        inBit <= 1'b0;
        if (trialC >= mbX) begin
          remR <= diffC[MAN_W-1:0];
          quoR <= {quoR[MAN_W-2:0], 1'b1};
        end else begin
          remR <= trialC[MAN_W-1:0];
          quoR <= {quoR[MAN_W-2:0], 1'b0};
        end
      end
      if (stb.rnd) begin
        if (sumC[MAN_W]) begin
          quoR <= {1'b1, {(MAN_W-1){1'b0}}};
          expR <= expR + $signed(EW'(1));
          if (expR == $signed(EW'(EMAX))) kindR <= K_OVF;
        end else begin
          quoR <= sumC[MAN_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quotient <= '0; done <= 1'b0; err <= 1'b0;
      ovfFlag <= 1'b0; unfFlag <= 1'b0; dzFlag <= 1'b0;
    end else begin
      done    <= stb.fin;
      ovfFlag <= (ovfFlag & ~clrFlags) | (stb.fin & (kindR == K_OVF));
      unfFlag <= (unfFlag & ~clrFlags) | (stb.fin & (kindR == K_UNF));
      dzFlag  <= (dzFlag  & ~clrFlags) | (stb.fin & (kindR == K_DZ));
      if (stb.fin) begin
        err <= (kindR == K_DZ) || (kindR == K_OVF) || (kindR == K_UNF);
        unique case (kindR)
          K_NORM:  quotient <= {expR[EXP_W-1:0], signR, quoR[FR_W-1:0]};
          K_OVF:   quotient <= satR ? {{EXP_W{1'b1}}, signR, {FR_W{1'b1}}} : '0;
          K_UNF:   quotient <= satR ? {{(EXP_W-1){1'b0}}, 1'b1, signR, {FR_W{1'b0}}} : '0;
          default: quotient <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/fpdiv_ctl.sv
module fpdiv_ctl
  import fpdiv_pkg::*;
#(
  parameter int MAN_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  divStat_t   stat,
  output divStrobe_t stb
);
  localparam int CNT_W = $clog2(MAN_W + 1);

  typedef enum logic [2:0] {S_IDLE, S_PREP, S_STEP, S_RND, S_FIN} ctlState_t;

  ctlState_t        state;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    stb      = '0;
    stb.load = (state == S_IDLE) && start;
    stb.prep = (state == S_PREP);
    stb.step = (state == S_STEP);
    stb.rnd  = (state == S_RND);
    stb.fin  = (state == S_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) state <= S_PREP;
        S_PREP: begin
          stepCnt <= '0;
          if (stat.bZero || stat.aZero || stat.expOvf || stat.expUnf) state <= S_FIN;
          else state <= S_STEP;
        end
        S_STEP: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == CNT_W'(MAN_W - 1)) state <= S_RND;
        end
        S_RND:   state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpdiv_top.sv
module fpdiv_top
  import fpdiv_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16,
  parameter int BIAS  = 127
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [EXP_W+MAN_W-1:0] dividend,
  input  logic [EXP_W+MAN_W-1:0] divisor,
  input  logic                   rndEn,
  input  logic                   satEn,
  input  logic                   clrFlags,
  output logic [EXP_W+MAN_W-1:0] quotient,
  output logic                   done,
  output logic                   err,
  output logic                   ovfFlag,
  output logic                   unfFlag,
  output logic                   dzFlag
);
  divStrobe_t stb;
  divStat_t   stat;

  fpdiv_ctl #(.MAN_W(MAN_W)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .stat(stat), .stb(stb)
  );

  fpdiv_dp #(.EXP_W(EXP_W), .MAN_W(MAN_W), .BIAS(BIAS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .aIn(dividend), .bIn(divisor),
    .rndIn(rndEn), .satIn(satEn), .clrFlags(clrFlags), .stat(stat),
    .quotient(quotient), .done(done), .err(err),
    .ovfFlag(ovfFlag), .unfFlag(unfFlag), .dzFlag(dzFlag)
  );
endmodule

// File: rtl/fpdiv_chk.sv
module fpdiv_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rstN,
  input logic         clrFlags,
  input logic [W-1:0] quotient,
  input logic         done,
  input logic         err,
  input logic         ovfFlag,
  input logic         unfFlag,
  input logic         dzFlag
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R4
  dz_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dzFlag) |-> done && err && (quotient == '0));
  // R6
  ovf_result_chk: assert property (@(posedge clk) disable iff (!rstN) $rose(ovfFlag) |-> done && err);
  // R7
  unf_result_chk: assert property (@(posedge clk) disable iff (!rstN) $rose(unfFlag) |-> done && err);
  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN) $rose(err) |-> done);
  // R8
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rstN) (ovfFlag && !clrFlags) |=> ovfFlag);
  // R8
  unf_hold_chk: assert property (@(posedge clk) disable iff (!rstN) (unfFlag && !clrFlags) |=> unfFlag);
  // R8
  dz_hold_chk: assert property (@(posedge clk) disable iff (!rstN) (dzFlag && !clrFlags) |=> dzFlag);
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrFlags |=> done || !(ovfFlag || unfFlag || dzFlag));
endmodule

bind fpdiv_top fpdiv_chk #(.W(EXP_W + MAN_W)) u_chk (
  .clk(clk), .rstN(rstN), .clrFlags(clrFlags), .quotient(quotient),
  .done(done), .err(err), .ovfFlag(ovfFlag), .unfFlag(unfFlag), .dzFlag(dzFlag)
);

// File: tb/sim_fpdiv_top.sv
module sim_fpdiv_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [23:0] dividend = '0, divisor = '0;
  logic        rndEn = 1'b0, satEn = 1'b0, clrFlags = 1'b0;
  logic [23:0] quotient;
  logic        done, err, ovfFlag, unfFlag, dzFlag;

  int checks = 0;
  int fails  = 0;
  logic [23:0] expQ[$];
  logic        expE[$];
  string       expT[$];

  always #10 clk = ~clk;

  fpdiv_top u0 (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend), .divisor(divisor),
    .rndEn(rndEn), .satEn(satEn), .clrFlags(clrFlags), .quotient(quotient),
    .done(done), .err(err), .ovfFlag(ovfFlag), .unfFlag(unfFlag), .dzFlag(dzFlag)
  );

  function automatic logic [24:0] refDiv(input logic [23:0] a, input logic [23:0] b,
                                         input logic rnd, input logic sat);
    longint ma, mb, num, q, nb, e;
    logic   s;
    if (b[23:16] == 0) return {1'b1, 24'h0};
    if (a[23:16] == 0) return {1'b0, 24'h0};
    s  = a[15] ^ b[15];
    ma = 32768 + a[14:0];
    mb = 32768 + b[14:0];
    num = (ma >= mb) ? (ma << 15) : (ma << 16);
    e   = longint'(a[23:16]) - longint'(b[23:16]) + 126 + ((ma >= mb) ? 1 : 0);
    if (e > 255) return sat ? {1'b1, 8'hFF, s, 15'h7FFF} : {1'b1, 24'h0};
    if (e <= 0)  return sat ? {1'b1, 8'h01, s, 15'h0} : {1'b1, 24'h0};
    q  = num / mb;
    nb = ((num * 2) / mb) % 2;
    if (rnd && (q % 2 == 1) && nb == 1) q = q + 1;
    if (q == 65536) begin
      q = 32768; e = e + 1;
      if (e > 255) return sat ? {1'b1, 8'hFF, s, 15'h7FFF} : {1'b1, 24'h0};
    end
    return {1'b0, e[7:0], s, q[14:0]};
  endfunction

  always @(negedge clk) begin
    if (rstN && done) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected done: actual q=%h expected no done", quotient);
      end else begin
        logic [23:0] q0; logic e0; string t0;
        q0 = expQ.pop_front(); e0 = expE.pop_front(); t0 = expT.pop_front();
        if (quotient !== q0 || err !== e0) begin
          fails++;
          $display("FAIL %s: actual q=%h err=%b expected q=%h err=%b", t0, quotient, err, q0, e0);
        end
      end
    end
  end

  task automatic runDiv(input logic [23:0] a, input logic [23:0] b, input logic rnd,
                        input logic sat, input logic [23:0] q, input logic e, input string tag);
    expQ.push_back(q); expE.push_back(e); expT.push_back(tag);
    @(negedge clk);
    dividend = a; divisor = b; rndEn = rnd; satEn = sat; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic runRef(input logic [23:0] a, input logic [23:0] b, input logic rnd,
                        input logic sat, input string tag);
    logic [24:0] r;
    r = refDiv(a, b, rnd, sat);
    runDiv(a, b, rnd, sat, r[23:0], r[24], tag);
  endtask

  task automatic chkFlags(input logic o, input logic u, input logic d, input string tag);
    checks++;
    if (ovfFlag !== o || unfFlag !== u || dzFlag !== d) begin
      fails++;
      $display("FAIL %s flags: actual ovf=%b unf=%b dz=%b expected ovf=%b unf=%b dz=%b",
               tag, ovfFlag, unfFlag, dzFlag, o, u, d);
    end
  endtask

  task automatic pulseClear();
    @(negedge clk); clrFlags = 1'b1;
    @(negedge clk); clrFlags = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (quotient !== 24'h0 || done !== 1'b0) begin
      fails++;
      $display("FAIL R9 reset: actual q=%h done=%b expected q=000000 done=0", quotient, done);
    end
    chkFlags(0, 0, 0, "R8 reset");
    rstN = 1'b1;
    @(negedge clk);

    runDiv(24'h7F0000, 24'h7F0000, 0, 0, 24'h7F0000, 0, "R2 1/1 aligned");
    runDiv(24'h804000, 24'h800000, 0, 0, 24'h7F4000, 0, "R2 3/2 aligned");
    runDiv(24'h7F0000, 24'h804000, 0, 0, 24'h7D2AAA, 0, "R1 1/3 unaligned");
    runDiv(24'h80C000, 24'h800000, 0, 0, 24'h7FC000, 0, "R1 -3/2 sign");
    runDiv(24'h80C000, 24'h808000, 0, 0, 24'h7F4000, 0, "R1 -3/-2 sign");
    runDiv(24'h7F0000, 24'h7F5000, 1, 0, 24'h7E1D8A, 0, "R3 odd LSB rounds up");
    runDiv(24'h7F0000, 24'h7F5000, 0, 0, 24'h7E1D89, 0, "R3 rounding off truncates");
    runDiv(24'h7F0000, 24'h7F2000, 1, 0, 24'h7E4CCC, 0, "R3 even LSB not rounded");
    chkFlags(0, 0, 0, "R8 no flags after normal results");

    runDiv(24'h000000, 24'h7F0000, 1, 1, 24'h000000, 0, "R5 zero dividend");
    chkFlags(0, 0, 0, "R5 zero dividend sets no flag");

    runDiv(24'h7F0000, 24'h000000, 1, 1, 24'h000000, 1, "R4 divide by zero");
    chkFlags(0, 0, 1, "R4 dz flag");
    pulseClear();
    chkFlags(0, 0, 0, "R8 clear");
    runDiv(24'h000000, 24'h000000, 0, 0, 24'h000000, 1, "R4 dz wins over zero dividend");
    chkFlags(0, 0, 1, "R4 priority flag");
    pulseClear();

    runDiv(24'hFF0000, 24'h010000, 0, 1, 24'hFF7FFF, 1, "R6 overflow saturated +");
    runDiv(24'hFF8000, 24'h010000, 0, 1, 24'hFFFFFF, 1, "R6 overflow saturated -");
    runDiv(24'hFF0000, 24'h010000, 0, 0, 24'h000000, 1, "R6 overflow unsaturated");
    chkFlags(1, 0, 0, "R6 ovf flag");
    runDiv(24'hFF0000, 24'h7E0000, 0, 1, 24'hFF7FFF, 1, "R6 exponent 256");
    runDiv(24'hFF0000, 24'h7F0000, 0, 1, 24'hFF0000, 0, "R6 exponent 255 normal");
    chkFlags(1, 0, 0, "R8 ovf sticky across normal op");
    pulseClear();

    runDiv(24'h010000, 24'hFF0000, 0, 1, 24'h010000, 1, "R7 underflow saturated +");
    runDiv(24'h018000, 24'hFF0000, 0, 1, 24'h018000, 1, "R7 underflow saturated -");
    runDiv(24'h010000, 24'hFF0000, 0, 0, 24'h000000, 1, "R7 underflow unsaturated");
    runDiv(24'h010000, 24'h800000, 0, 1, 24'h010000, 1, "R7 exponent 0");
    runDiv(24'h010000, 24'h7F0000, 0, 1, 24'h010000, 0, "R7 exponent 1 normal");
    chkFlags(0, 1, 0, "R8 unf sticky");
    pulseClear();
    chkFlags(0, 0, 0, "R8 clear after unf");

    // R9: a second start while busy must be ignored
    expQ.push_back(24'h7F4000); expE.push_back(1'b0); expT.push_back("R9 busy start ignored");
    @(negedge clk);
    dividend = 24'h804000; divisor = 24'h800000; rndEn = 0; satEn = 0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    dividend = 24'h7F0000; divisor = 24'h000000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    repeat (25) @(negedge clk);
    chkFlags(0, 0, 0, "R9 ignored start left no dz");

    for (int i = 0; i < 60; i++) begin
      logic [23:0] a, b;
      a = {8'(90 + $urandom_range(0, 70)), 1'($urandom), 15'($urandom)};
      b = {8'(90 + $urandom_range(0, 70)), 1'($urandom), 15'($urandom)};
      runRef(a, b, 1'($urandom), 1'($urandom), "R1 R3 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule